// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Sequencer

This block sits between a set of peripheral request lines and the program counter of a small processor core. Every source owns a sticky pending flag and an enable bit, and one global enable gates all of them. When the core reaches an instruction boundary, or is asleep, the block picks the pending and enabled source with the lowest index. It then runs a fixed entry sequence: it pushes the current 9-bit program counter and loads the source's vector address into the program counter.

A return strobe from the core starts a fixed return sequence. That sequence pops the saved program counter, reloads it, and turns the global enable back on. After a return, the interrupted program must complete at least one instruction before any pending request is taken. Software sets the enables and the global enable, and clears flags, through a three-register write port. The block only issues push and pop requests. The stack storage and instruction decode sit elsewhere, and no status register is saved.

Top module: `irq_seq`

## Requirements
- R1: After reset, all pending flags, the enable mask and the global enable are 0, `busy` is low, and no push, pop or load is issued.
- R2: A pulse on `src_evt[i]` sets pending flag i whether or not its enable or the global enable is on. The flag stays set until software clears it or hardware services it.
- R3: A bus write to address 1 clears every pending flag whose data bit is 1. A request arriving in the same cycle as that clear leaves the flag set.
- R4: Bus address 0 writes the enable mask and bus address 2 writes the global enable from data bit 0. A source is taken only when its flag, its enable bit and the global enable are all 1.
- R5: Among the requests that are both pending and enabled, the lowest bit index wins. Source bit i has vector address i+1.
- R6: When a request is accepted in cycle A, the global enable reads 0 from cycle A+1. `push_req` is high in cycle A+1 with `push_data` equal to `cur_pc` as sampled in cycle A. `pc_load` is high in cycle A+4 with the vector.
- R7: The flag of the serviced source is cleared at the end of its `pc_load` cycle, unless that source requests again in the same cycle.
- R8: If `core_sleep` is high in the cycle of acceptance, the push moves to A+5 and the load to A+8. While asleep, a request is accepted without an instruction boundary.
- R9: A `reti` pulse in cycle B, while idle, gives `pop_req` in cycle B+1, and `pop_data` is captured in that cycle. `pc_load` follows in cycle B+4 carrying the popped value, and the global enable reads 1 from cycle B+5.
- R10: After a return, the first `insn_boundary` pulse is not used to accept a request. The earliest acceptance is at the second boundary pulse.
- R11: While `insn_boundary` and `core_sleep` are both low, no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Per-source request pulses; bit i is source i (vector i+1) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 enable mask, 1 flag clear (write one), 2 global enable |
| bus_wdata | input | NSRC | Write data |
| insn_boundary | input | 1 | Core completes an instruction this cycle |
| core_sleep | input | 1 | Core is in sleep state |
| reti | input | 1 | Return-from-interrupt strobe |
| cur_pc | input | PC_W | Program counter to save on entry |
| pop_data | input | PC_W | Stack data, valid in the pop cycle |
| push_req | output | 1 | Push request to the stack |
| push_data | output | PC_W | Program counter being pushed |
| pop_req | output | 1 | Pop request to the stack |
| pc_load | output | 1 | Load the program counter this cycle |
| pc_load_val | output | PC_W | Vector address or restored program counter |
| pend_flags | output | NSRC | Current pending flags |
| gie | output | 1 | Global enable state |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
Hardware clearing of the serviced flag and a fresh request from that same source can land in the same cycle. The bench provokes this by pulsing the source exactly in the cycle where `pc_load` delivers its vector. It judges the result by reading `pend_flags` one cycle later: the flag must still be set. In the same way, a software write-one clear is issued together with a request on the same bit, and the flag must survive. Entry and return timing is judged by a scoreboard that predicts the exact cycle and value of every push, pop and load.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int MAX_SRC = 32;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WAKE   = 2'd1,
    SQ_ENTER  = 2'd2,
    SQ_RETURN = 2'd3
  } seq_state_e;

  localparam logic [1:0] ADDR_EN  = 2'd0;
  localparam logic [1:0] ADDR_CLR = 2'd1;
  localparam logic [1:0] ADDR_GIE = 2'd2;

  // lowest set bit index; 0 when no bit is set
  function automatic int unsigned lowest_set(input logic [MAX_SRC-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = unsigned'(i);
    end
    return r;
  endfunction

  // vector address for a source index
  function automatic int unsigned vector_for(input int unsigned idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] hw_clr,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] en
);

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[g] <= 1'b0;
      end else begin
        // a new request outranks either kind of clear
        flags[g] <= evt[g] | (flags[g] & ~sw_clr[g] & ~hw_clr[g]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0;
    end else if (en_we) begin
      en <= en_wdata;
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int PC_W = 9
) (
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] en,
  output logic            any,
  output logic [PC_W-1:0] vec,
  output logic [NSRC-1:0] onehot
);

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]    req;
  logic [MAX_SRC-1:0] req_ext;
  logic [IDX_W-1:0]   sel_idx;

  always_comb begin
    req     = flags & en;
    req_ext = MAX_SRC'(req);
    any     = |req;
    sel_idx = IDX_W'(lowest_set(req_ext));
    vec     = PC_W'(vector_for(int'(sel_idx)));
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_oh
    assign onehot[g] = any && (sel_idx == IDX_W'(g));
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int NSRC      = 4,
  parameter int PC_W      = 9,
  parameter int ENTRY_CYC = 4,
  parameter int WAKE_CYC  = 4,
  parameter int RET_CYC   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend_any,
  input  logic [PC_W-1:0] pick_vec,
  input  logic [NSRC-1:0] pick_oh,
  input  logic            insn_boundary,
  input  logic            core_sleep,
  input  logic            reti,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] pop_data,
  input  logic            gie_we,
  input  logic            gie_wdata,
  output logic            gie,
  output logic            busy,
  output logic            take,
  output logic            ret_done,
  output logic            push_req,
  output logic [PC_W-1:0] push_data,
  output logic            pop_req,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_load_val,
  output logic [NSRC-1:0] svc_clr
);

  localparam int MAX_A  = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
  localparam int MAX_C  = (MAX_A > RET_CYC) ? MAX_A : RET_CYC;
  localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] ENT_END  = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_END = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] RET_END  = CNT_W'(RET_CYC - 1);

  seq_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] vec_q;
  logic [NSRC-1:0] oh_q;
  logic            gie_q;
  logic            after_ret_q;

  logic idle, ret_start, wake_end, ent_last;

  always_comb begin
    idle      = (st_q == SQ_IDLE);
    ret_start = idle && reti;
    // a return strobe outranks a new acceptance in the same cycle
    take      = idle && !reti && gie_q && pend_any &&
                ((insn_boundary && !after_ret_q) || core_sleep);
    wake_end  = (st_q == SQ_WAKE)   && (cnt_q == WAKE_END);
    push_req  = (st_q == SQ_ENTER)  && (cnt_q == '0);
    ent_last  = (st_q == SQ_ENTER)  && (cnt_q == ENT_END);
    pop_req   = (st_q == SQ_RETURN) && (cnt_q == '0);
    ret_done  = (st_q == SQ_RETURN) && (cnt_q == RET_END);
    pc_load   = ent_last || ret_done;
    if (ent_last)     pc_load_val = vec_q;
    else if (pop_req) pc_load_val = pop_data;
    else              pc_load_val = pc_q;
    push_data = pc_q;
    svc_clr   = ent_last ? oh_q : '0;
    busy      = !idle;
    gie       = gie_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      pc_q  <= '0;
      vec_q <= '0;
      oh_q  <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (ret_start) begin
            st_q <= SQ_RETURN;
          end else if (take) begin
            st_q  <= core_sleep ? SQ_WAKE : SQ_ENTER;
            pc_q  <= cur_pc;
            vec_q <= pick_vec;
            oh_q  <= pick_oh;
          end
        end
        SQ_WAKE: begin
          if (wake_end) begin
            st_q  <= SQ_ENTER;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_ENTER: begin
          if (ent_last) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_RETURN: begin
          if (pop_req) pc_q <= pop_data;
          if (ret_done) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q       <= 1'b0;
      after_ret_q <= 1'b0;
    end else begin
      if (take)          gie_q <= 1'b0;
      else if (ret_done) gie_q <= 1'b1;
      else if (gie_we)   gie_q <= gie_wdata;

      if (ret_done)           after_ret_q <= 1'b1;
      else if (insn_boundary) after_ret_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int PC_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  input  logic            insn_boundary,
  input  logic            core_sleep,
  input  logic            reti,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] pop_data,
  output logic            push_req,
  output logic [PC_W-1:0] push_data,
  output logic            pop_req,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_load_val,
  output logic [NSRC-1:0] pend_flags,
  output logic            gie,
  output logic            busy
);

  logic            en_we, gie_we;
  logic [NSRC-1:0] sw_clr, svc_clr, en_q, flags_q, pick_oh;
  logic [PC_W-1:0] pick_vec;
  logic            pend_any, take_w, ret_done_w;

  always_comb begin
    en_we  = bus_we && (bus_addr == ADDR_EN);
    gie_we = bus_we && (bus_addr == ADDR_GIE);
    sw_clr = (bus_we && (bus_addr == ADDR_CLR)) ? bus_wdata : '0;
  end

  irq_flag_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .sw_clr(sw_clr),
    .hw_clr(svc_clr), .en_we(en_we), .en_wdata(bus_wdata),
    .flags(flags_q), .en(en_q)
  );

  irq_pick #(.NSRC(NSRC), .PC_W(PC_W)) u_pick (
    .flags(flags_q), .en(en_q), .any(pend_any), .vec(pick_vec),
    .onehot(pick_oh)
  );

  irq_seq_fsm #(.NSRC(NSRC), .PC_W(PC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .pick_vec(pick_vec),
    .pick_oh(pick_oh), .insn_boundary(insn_boundary),
    .core_sleep(core_sleep), .reti(reti), .cur_pc(cur_pc),
    .pop_data(pop_data), .gie_we(gie_we), .gie_wdata(bus_wdata[0]),
    .gie(gie), .busy(busy), .take(take_w), .ret_done(ret_done_w),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .svc_clr(svc_clr)
  );

  assign pend_flags = flags_q;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take,
  input logic            ret_done,
  input logic            gie,
  input logic            push_req,
  input logic            pop_req,
  input logic            pc_load,
  input logic [NSRC-1:0] pend_flags,
  input logic [NSRC-1:0] en_mask,
  input logic            bus_we,
  input logic            insn_boundary,
  input logic            core_sleep
);

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !pc_load) |=> ((pend_flags & $past(pend_flags)) == $past(pend_flags)));

  p_take_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gie && ((pend_flags & en_mask) != '0)));

  p_gie_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);

  p_push_to_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> ##3 pc_load);

  p_stack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_req, pop_req, pc_load}));

  p_pop_to_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> ##3 pc_load);

  p_gie_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> ##4 gie);

  p_one_insn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> (!take || core_sleep));

  p_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (insn_boundary || core_sleep));

endmodule

bind irq_seq irq_seq_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take_w), .ret_done(ret_done_w),
  .gie(gie), .push_req(push_req), .pop_req(pop_req), .pc_load(pc_load),
  .pend_flags(pend_flags), .en_mask(en_q), .bus_we(bus_we),
  .insn_boundary(insn_boundary), .core_sleep(core_sleep)
);

// File: tb/irq_seq_bench.sv
`timescale 1ns/1ps
module irq_seq_bench;

  localparam int NSRC = 4;
  localparam int PC_W = 9;
  localparam int K_PUSH = 0, K_POP = 1, K_LOAD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_evt = '0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic insn_boundary = 1'b0, core_sleep = 1'b0, reti = 1'b0;
  logic [PC_W-1:0] cur_pc = '0, pop_data = '0;
  logic push_req, pop_req, pc_load, gie, busy;
  logic [PC_W-1:0] push_data, pc_load_val;
  logic [NSRC-1:0] pend_flags;

  int cyc = 0;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  int q_cyc[$], q_kind[$], q_val[$];
  string q_req[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_seq u_irq_seq (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .insn_boundary(insn_boundary), .core_sleep(core_sleep), .reti(reti),
    .cur_pc(cur_pc), .pop_data(pop_data), .push_req(push_req),
    .push_data(push_data), .pop_req(pop_req), .pc_load(pc_load),
    .pc_load_val(pc_load_val), .pend_flags(pend_flags), .gie(gie),
    .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_item(int c, int kind, int val, string req);
    q_cyc.push_back(c);
    q_kind.push_back(kind);
    q_val.push_back(val);
    q_req.push_back(req);
  endtask

  // acceptance in cycle c; extra = 4 when the core is asleep
  task automatic expect_entry(int c, int extra, int pc, int vec, string req);
    expect_item(c + 1 + extra, K_PUSH, pc, req);
    expect_item(c + 4 + extra, K_LOAD, vec, req);
  endtask

  task automatic expect_return(int c, int pc);
    expect_item(c + 1, K_POP, 0, "R9");
    expect_item(c + 4, K_LOAD, pc, "R9");
  endtask

  task automatic bus_w(logic [1:0] a, logic [NSRC-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic observe(int kind, int val);
    string r;
    if (q_cyc.size() == 0) begin
      check("R6/R9 unexpected stack or load event", kind, -1);
    end else begin
      r = q_req.pop_front();
      check({r, " event kind"}, kind, q_kind.pop_front());
      check({r, " event cycle"}, cyc, q_cyc.pop_front());
      check({r, " event value"}, val, q_val.pop_front());
    end
  endtask

  // monitor: compares produced events with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (push_req) observe(K_PUSH, int'(push_data));
      if (pop_req)  observe(K_POP, 0);
      if (pc_load)  observe(K_LOAD, int'(pc_load_val));
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 flags", int'(pend_flags), 0);
    check("R1 gie", int'(gie), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 no stack/load", int'({push_req, pop_req, pc_load}), 0);
    insn_boundary = 1'b1;

    // R2: flag latches with all enables off
    src_evt = 4'b0001; tick(1); src_evt = '0;
    check("R2 flag set", int'(pend_flags), 1);
    tick(3);
    check("R2 flag held", int'(pend_flags), 1);

    // R4: global enable on, source enable off -> not taken
    bus_w(2'd2, 4'b0001);
    tick(3);
    check("R4 gie written", int'(gie), 1);
    check("R4 disabled source ignored", int'(busy), 0);

    // R11: enabled and pending but mid-instruction
    insn_boundary = 1'b0;
    bus_w(2'd0, 4'b1111);
    tick(4);
    check("R11 waits for boundary", int'(busy), 0);
    c = cyc; cur_pc = 9'h123;
    expect_entry(c, 0, 'h123, 1, "R6");
    insn_boundary = 1'b1;
    tick(1);
    insn_boundary = 1'b0;
    check("R6 gie cleared", int'(gie), 0);
    check("R6 busy", int'(busy), 1);
    tick(4);
    check("R7 serviced flag cleared", int'(pend_flags), 0);
    check("R6 idle after entry", int'(busy), 0);

    // R5 / R10: two pending while masked, then return
    src_evt = 4'b0110; tick(1); src_evt = '0;
    check("R2 held while masked", int'(pend_flags), 6);
    pop_data = 9'h0AB; cur_pc = 9'h050;
    c = cyc; reti = 1'b1;
    expect_return(c, 'h0AB);
    expect_entry(c + 6, 0, 'h050, 2, "R5 R10");
    tick(1); reti = 1'b0;
    tick(4);
    check("R9 gie restored", int'(gie), 1);
    insn_boundary = 1'b1;
    check("R10 not yet taken", int'(busy), 0);
    tick(2);
    check("R10 taken at second boundary", int'(busy), 1);
    tick(4);
    check("R5 lower index served first", int'(pend_flags), 4);
    check("R6 gie off again", int'(gie), 0);

    // R7: new request in the load cycle of the same source
    c = cyc; reti = 1'b1;
    expect_return(c, 'h0AB);
    expect_entry(c + 6, 0, 'h050, 3, "R7");
    tick(1); reti = 1'b0;
    tick(9);
    src_evt = 4'b0100; tick(1); src_evt = '0;
    check("R7 same-cycle request survives clear", int'(pend_flags), 4);

    // R3: write-one clear, and clear racing a request
    bus_w(2'd1, 4'b0100);
    check("R3 cleared by write", int'(pend_flags), 0);
    src_evt = 4'b0001; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 4'b0001;
    tick(1);
    src_evt = '0; bus_we = 1'b0; bus_wdata = '0;
    check("R3 request beats clear", int'(pend_flags), 1);
    bus_w(2'd1, 4'b0001);
    check("R3 cleared again", int'(pend_flags), 0);

    // R8: acceptance while asleep
    insn_boundary = 1'b0;
    c = cyc; reti = 1'b1;
    expect_return(c, 'h0AB);
    tick(1); reti = 1'b0;
    tick(4);
    core_sleep = 1'b1; src_evt = 4'b1000;
    expect_entry(c + 6, 4, 'h050, 4, "R8");
    tick(1); src_evt = '0;
    tick(1); core_sleep = 1'b0;
    tick(10);
    check("R8 flag serviced", int'(pend_flags), 0);
    check("R8 gie off", int'(gie), 0);
    check("R6 R9 all predicted events seen", q_cyc.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule